// File: doc/BRIEF.md
# Endian-Selectable Bus Width Matcher

This block adapts a 36-bit FIFO word interface to a narrower external port that may be 36, 18 or 9 bits wide. On the read path it takes the word at the head of a FIFO and presents it to the port as one, two or four beats. The FIFO word is removed only after its final beat has gone out. On the write path it gathers one, two or four port beats into a full 36-bit word and pushes that word into a FIFO once it is complete.

The port width and the byte order are sampled from three configuration inputs while master reset is high. They stay fixed until the next master reset. A partial reset drops any half-sent or half-assembled word and clears the port-side output register, but keeps the sampled configuration. The FIFO storage, its flags and the pin tristate control sit outside this block.

Top module: `bus_width_matcher`

## Requirements
- R1: With `cfg_bus_match` low at master reset, the port is 36 bits wide. Every accepted read beat carries a whole FIFO word and pops it. Every write beat pushes its whole 36-bit value.
- R2: With `cfg_bus_match` high and `cfg_size` low at master reset, the port is 18 bits wide. Each word is moved as two halves, bits [35:18] and bits [17:0].
- R3: With `cfg_bus_match` high and `cfg_size` high at master reset, the port is 9 bits wide. Each word is moved as four lanes, lane i being bits [9i+8:9i].
- R4: With `cfg_big` high at master reset, the most significant half or lane is transferred first on both paths.
- R5: With `cfg_big` low at master reset, the least significant half or lane is transferred first on both paths.
- R6: The configuration inputs are sampled only in cycles where `mst_rst` is high. Changing them at any other time has no effect, and a partial reset keeps the sampled values.
- R7: The clock edge that samples `mst_rst` or `part_rst` high clears `nb_rd_data` to zero and leaves `fifo_wr_push` low in the next cycle.
- R8: A read beat is accepted when `nb_rd_en` and `fifo_rd_valid` are both high. It updates `nb_rd_data` at the next edge. `fifo_rd_pop` is high, in the same cycle, only for the final beat of a word. With no accepted beat, `nb_rd_data` holds its value and there is no pop.
- R9: On a write beat where `nb_wr_en` is high, `nb_wr_data` is taken in. The cycle after the beat that completes a word, `fifo_wr_push` is high for exactly one cycle and `fifo_wr_data` holds the assembled word. No other beat causes a push.
- R10: After a partial reset, the next read beat is the first beat of the word at the FIFO head. The next write beat starts a new word, and earlier partial beats are dropped.
- R11: In the 18-bit and 9-bit modes, the unused upper bits of `nb_rd_data` read as zero, and the unused upper bits of `nb_wr_data` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both paths |
| mst_rst | input | 1 | Synchronous master reset; samples the configuration |
| part_rst | input | 1 | Synchronous partial reset; flushes beat state and keeps the configuration |
| cfg_bus_match | input | 1 | Low selects 36-bit port; high selects a narrow port |
| cfg_size | input | 1 | With bus match high: high selects 9-bit, low selects 18-bit |
| cfg_big | input | 1 | High selects most-significant-first order |
| fifo_rd_data | input | 36 | Word at the head of the outbound FIFO |
| fifo_rd_valid | input | 1 | Outbound FIFO holds a word |
| fifo_rd_pop | output | 1 | Remove the head word this cycle |
| nb_rd_en | input | 1 | Port requests a read beat |
| nb_rd_data | output | 36 | Registered read beat, right-aligned |
| nb_wr_en | input | 1 | Port presents a write beat |
| nb_wr_data | input | 36 | Write beat, right-aligned |
| fifo_wr_push | output | 1 | Push the assembled word into the inbound FIFO |
| fifo_wr_data | output | 36 | Assembled word to push |

## Verification
The bench targets these corner cases:
- Beat order flips between the two endian settings. A swapped lane index would emit halves or lanes in the wrong order, or place write beats in the wrong field.
- Read requests arrive while the FIFO is empty, and read and write idle gaps fall in the middle of a word. A design that advanced its beat counter on those cycles would pop early or skip a lane.
- Partial reset arrives mid-word. A design that kept its counter or its assembly register would emit a middle lane first or push a word mixed with stale data, and one that cleared the configuration would fall back to 36-bit transfers.
- Configuration inputs change after master reset. A design that tracked them live would change width under traffic.

// File: rtl/bwm_pkg.sv
package bwm_pkg;

    typedef enum logic [1:0] {
        BUS_LONG = 2'd0,
        BUS_HALF = 2'd1,
        BUS_BYTE = 2'd2
    } bus_mode_e;

    typedef struct packed {
        bus_mode_e mode;
        logic      big;
    } bus_cfg_t;

endpackage

// File: rtl/bwm_cfg_latch.sv
module bwm_cfg_latch
    import bwm_pkg::*;
(
    input  logic     clk,
    input  logic     mst_rst,
    input  logic     cfg_bus_match,
    input  logic     cfg_size,
    input  logic     cfg_big,
    output bus_cfg_t cfg
);
    bus_cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (mst_rst) begin
            cfg_d.big = cfg_big;
            if (!cfg_bus_match) cfg_d.mode = BUS_LONG;
            else if (cfg_size)  cfg_d.mode = BUS_BYTE;
            else                cfg_d.mode = BUS_HALF;
        end
    end

    always_ff @(posedge clk) cfg_q <= cfg_d;

    assign cfg = cfg_q;
endmodule

// File: rtl/bwm_lane_sel.sv
module bwm_lane_sel
    import bwm_pkg::*;
#(
    parameter int WORD_W = 36,
    parameter int LANES  = 4,
    localparam int CNT_W = $clog2(LANES),
    localparam int SH_W  = $clog2(WORD_W)
) (
    input  bus_cfg_t           cfg,
    input  logic [CNT_W-1:0]   cnt,
    output logic [SH_W-1:0]    shift,
    output logic [WORD_W-1:0]  mask,
    output logic               last
);
    logic [CNT_W-1:0] beats_m1;
    logic [CNT_W-1:0] idx;
    int               fw;

    always_comb begin
        unique case (cfg.mode)
            BUS_LONG: begin beats_m1 = '0;                fw = WORD_W;         end
            BUS_HALF: begin beats_m1 = CNT_W'(1);         fw = WORD_W / 2;     end
            default:  begin beats_m1 = CNT_W'(LANES - 1); fw = WORD_W / LANES; end
        endcase
        idx   = cfg.big ? (beats_m1 - cnt) : cnt;
        shift = SH_W'(int'(idx) * fw);
        mask  = {WORD_W{1'b1}} >> (WORD_W - fw);
        last  = (cnt == beats_m1);
    end
endmodule

// File: rtl/bwm_rd_split.sv
module bwm_rd_split
    import bwm_pkg::*;
#(
    parameter int WORD_W = 36,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic              clr,
    input  bus_cfg_t          cfg,
    input  logic [WORD_W-1:0] word,
    input  logic              word_valid,
    input  logic              beat_en,
    output logic              pop,
    output logic [WORD_W-1:0] beat
);
    localparam int CNT_W = $clog2(LANES);
    localparam int SH_W  = $clog2(WORD_W);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [WORD_W-1:0] dout;
    } rd_state_t;

    rd_state_t         st_d, st_q;
    logic [SH_W-1:0]   shift;
    logic [WORD_W-1:0] mask;
    logic              last;
    logic              take;

    bwm_lane_sel #(.WORD_W(WORD_W), .LANES(LANES)) u_sel (
        .cfg   (cfg),
        .cnt   (st_q.cnt),
        .shift (shift),
        .mask  (mask),
        .last  (last)
    );

    always_comb begin
        st_d = st_q;
        take = beat_en && word_valid && !clr;
        if (clr) begin
            st_d = '0;
        end else if (take) begin
            st_d.dout = (word >> shift) & mask;
            st_d.cnt  = last ? '0 : st_q.cnt + 1'b1;
        end
        pop = take && last;
    end

    always_ff @(posedge clk) st_q <= st_d;

    assign beat = st_q.dout;
endmodule

// File: rtl/bwm_wr_pack.sv
module bwm_wr_pack
    import bwm_pkg::*;
#(
    parameter int WORD_W = 36,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic              clr,
    input  bus_cfg_t          cfg,
    input  logic              beat_en,
    input  logic [WORD_W-1:0] beat,
    output logic              push,
    output logic [WORD_W-1:0] word
);
    localparam int CNT_W = $clog2(LANES);
    localparam int SH_W  = $clog2(WORD_W);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [WORD_W-1:0] acc;
        logic              push;
        logic [WORD_W-1:0] wdata;
    } wr_state_t;

    wr_state_t         st_d, st_q;
    logic [SH_W-1:0]   shift;
    logic [WORD_W-1:0] mask;
    logic              last;
    logic [WORD_W-1:0] merged;

    bwm_lane_sel #(.WORD_W(WORD_W), .LANES(LANES)) u_sel (
        .cfg   (cfg),
        .cnt   (st_q.cnt),
        .shift (shift),
        .mask  (mask),
        .last  (last)
    );

    always_comb begin
        st_d      = st_q;
        st_d.push = 1'b0;
        merged    = (st_q.acc & ~(mask << shift)) | ((beat & mask) << shift);
        if (clr) begin
            st_d = '0;
        end else if (beat_en) begin
            if (last) begin
                st_d.push  = 1'b1;
                st_d.wdata = merged;
                st_d.acc   = '0;
                st_d.cnt   = '0;
            end else begin
                st_d.acc = merged;
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) st_q <= st_d;

    assign push = st_q.push;
    assign word = st_q.wdata;
endmodule

// File: rtl/bus_width_matcher.sv
module bus_width_matcher
    import bwm_pkg::*;
#(
    parameter int WORD_W = 36,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic              mst_rst,
    input  logic              part_rst,
    input  logic              cfg_bus_match,
    input  logic              cfg_size,
    input  logic              cfg_big,
    input  logic [WORD_W-1:0] fifo_rd_data,
    input  logic              fifo_rd_valid,
    output logic              fifo_rd_pop,
    input  logic              nb_rd_en,
    output logic [WORD_W-1:0] nb_rd_data,
    input  logic              nb_wr_en,
    input  logic [WORD_W-1:0] nb_wr_data,
    output logic              fifo_wr_push,
    output logic [WORD_W-1:0] fifo_wr_data
);
    bus_cfg_t cfg;
    logic     clr;

    assign clr = mst_rst || part_rst;

    bwm_cfg_latch u_cfg (
        .clk           (clk),
        .mst_rst       (mst_rst),
        .cfg_bus_match (cfg_bus_match),
        .cfg_size      (cfg_size),
        .cfg_big       (cfg_big),
        .cfg           (cfg)
    );

    bwm_rd_split #(.WORD_W(WORD_W), .LANES(LANES)) u_rd (
        .clk        (clk),
        .clr        (clr),
        .cfg        (cfg),
        .word       (fifo_rd_data),
        .word_valid (fifo_rd_valid),
        .beat_en    (nb_rd_en),
        .pop        (fifo_rd_pop),
        .beat       (nb_rd_data)
    );

    bwm_wr_pack #(.WORD_W(WORD_W), .LANES(LANES)) u_wr (
        .clk     (clk),
        .clr     (clr),
        .cfg     (cfg),
        .beat_en (nb_wr_en),
        .beat    (nb_wr_data),
        .push    (fifo_wr_push),
        .word    (fifo_wr_data)
    );
endmodule

// File: rtl/bwm_checker.sv
module bwm_checker #(
    parameter int WORD_W = 36,
    parameter int LANES  = 4
) (
    input logic              clk,
    input logic              mst_rst,
    input logic              part_rst,
    input logic              cfg_bus_match,
    input logic              cfg_size,
    input logic              cfg_big,
    input logic [WORD_W-1:0] fifo_rd_data,
    input logic              fifo_rd_valid,
    input logic              fifo_rd_pop,
    input logic              nb_rd_en,
    input logic [WORD_W-1:0] nb_rd_data,
    input logic              nb_wr_en,
    input logic [WORD_W-1:0] nb_wr_data,
    input logic              fifo_wr_push,
    input logic [WORD_W-1:0] fifo_wr_data
);
    localparam int LANE_W = WORD_W / LANES;
    localparam int HALF_W = WORD_W / 2;

    logic seen_q = 1'b0;
    logic narrow_q, byte_q;

    always_ff @(posedge clk) begin
        if (mst_rst) begin
            seen_q   <= 1'b1;
            narrow_q <= cfg_bus_match;
            byte_q   <= cfg_bus_match && cfg_size;
        end
    end

    AST_RST_CLEARS_OUT: assert property (@(posedge clk)
        (mst_rst || part_rst) |=> (nb_rd_data == '0 && !fifo_wr_push)); // R7

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (mst_rst || part_rst || !seen_q)
        !(nb_rd_en && fifo_rd_valid) |=> $stable(nb_rd_data)); // R8

    AST_POP_NEEDS_BEAT: assert property (@(posedge clk) disable iff (mst_rst || part_rst || !seen_q)
        fifo_rd_pop |-> (nb_rd_en && fifo_rd_valid)); // R8

    AST_NARROW_POP_GAP: assert property (@(posedge clk) disable iff (mst_rst || part_rst || !seen_q)
        (narrow_q && fifo_rd_pop) |=> !fifo_rd_pop); // R8

    AST_NARROW_PUSH_GAP: assert property (@(posedge clk) disable iff (mst_rst || part_rst || !seen_q)
        (narrow_q && fifo_wr_push) |=> !fifo_wr_push); // R9

    AST_WIDE_POP_EACH: assert property (@(posedge clk) disable iff (mst_rst || part_rst || !seen_q)
        (!narrow_q && nb_rd_en && fifo_rd_valid) |-> fifo_rd_pop); // R1

    AST_BYTE_UPPER_ZERO: assert property (@(posedge clk) disable iff (mst_rst || !seen_q)
        byte_q |-> (nb_rd_data[WORD_W-1:LANE_W] == '0)); // R11

    AST_HALF_UPPER_ZERO: assert property (@(posedge clk) disable iff (mst_rst || !seen_q)
        narrow_q |-> (nb_rd_data[WORD_W-1:HALF_W] == '0)); // R11
endmodule

bind bus_width_matcher bwm_checker #(.WORD_W(WORD_W), .LANES(LANES)) u_chk (.*);

// File: tb/bus_width_matcher_bench.sv
`timescale 1ns/1ps
module bus_width_matcher_bench;
    logic        clk = 1'b0;
    logic        mst_rst = 1'b0, part_rst = 1'b0;
    logic        cfg_bus_match = 1'b0, cfg_size = 1'b0, cfg_big = 1'b0;
    logic [35:0] fifo_rd_data = '0;
    logic        fifo_rd_valid = 1'b0;
    logic        fifo_rd_pop;
    logic        nb_rd_en = 1'b0;
    logic [35:0] nb_rd_data;
    logic        nb_wr_en = 1'b0;
    logic [35:0] nb_wr_data = '0;
    logic        fifo_wr_push;
    logic [35:0] fifo_wr_data;

    always #2 clk = ~clk;

    bus_width_matcher u_bus_width_matcher (.*);

    int checks = 0, errors = 0;
    bit done = 0;

    // bench model state
    int          mode;     // 0 long, 1 half, 2 byte
    bit          big;
    logic [35:0] rq[$];
    int          rb, wb;
    logic [35:0] exp_rd, wacc;
    string       tag;

    function automatic int nbeats(int m);
        return (m == 0) ? 1 : (m == 1) ? 2 : 4;
    endfunction

    function automatic logic [35:0] lane_of(logic [35:0] w, int m, bit b, int k);
        int i;
        if (m == 0) return w;
        i = b ? nbeats(m) - 1 - k : k;
        if (m == 1) return (i == 1) ? {18'd0, w[35:18]} : {18'd0, w[17:0]};
        return {27'd0, w[i*9 +: 9]};
    endfunction

    function automatic logic [35:0] place(logic [35:0] acc, logic [35:0] v, int m, bit b, int k);
        int i;
        logic [35:0] r;
        r = acc;
        if (m == 0) return v;
        i = b ? nbeats(m) - 1 - k : k;
        if (m == 1) begin
            if (i == 1) r[35:18] = v[17:0]; else r[17:0] = v[17:0];
        end else begin
            r[i*9 +: 9] = v[8:0];
        end
        return r;
    endfunction

    task automatic check(bit ok, string req, logic [35:0] act, logic [35:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one cycle: entered and left at a negedge
    task automatic step(bit rd_i, bit wr_i, logic [35:0] wv);
        bit take, exp_pop, exp_push;
        nb_rd_en      = rd_i;
        fifo_rd_valid = (rq.size() > 0);
        fifo_rd_data  = fifo_rd_valid ? rq[0] : 36'($urandom);
        nb_wr_en      = wr_i;
        nb_wr_data    = wv;
        take    = rd_i && fifo_rd_valid;
        exp_pop = take && (rb == nbeats(mode) - 1);
        #0.5;
        check(fifo_rd_pop == exp_pop, {tag, " R8 pop"}, 36'(fifo_rd_pop), 36'(exp_pop));
        if (take) begin
            exp_rd = lane_of(rq[0], mode, big, rb);
            rb = (rb == nbeats(mode) - 1) ? 0 : rb + 1;
            if (exp_pop) void'(rq.pop_front());
        end
        exp_push = 1'b0;
        if (wr_i) begin
            wacc = place(wacc, wv, mode, big, wb);
            if (wb == nbeats(mode) - 1) begin exp_push = 1'b1; wb = 0; end
            else wb++;
        end
        @(posedge clk);
        @(negedge clk);
        check(nb_rd_data == exp_rd, {tag, " R8/R11 read beat"}, nb_rd_data, exp_rd);
        check(fifo_wr_push == exp_push, {tag, " R9 push"}, 36'(fifo_wr_push), 36'(exp_push));
        if (exp_push) begin
            check(fifo_wr_data == wacc, {tag, " R9/R11 packed word"}, fifo_wr_data, wacc);
            wacc = '0;
        end
    endtask

    task automatic clear_model();
        rb = 0; wb = 0; exp_rd = '0; wacc = '0;
    endtask

    task automatic do_mrst(bit bm, bit sz, bit b);
        mst_rst = 1'b1; cfg_bus_match = bm; cfg_size = sz; cfg_big = b;
        nb_rd_en = 1'b0; nb_wr_en = 1'b0;
        @(posedge clk); @(negedge clk);
        mst_rst = 1'b0;
        // R6: scramble config inputs after sampling
        cfg_bus_match = ~bm; cfg_size = ~sz; cfg_big = ~b;
        mode = !bm ? 0 : (sz ? 2 : 1);
        big  = b;
        clear_model();
        check(nb_rd_data == '0, "R7 master reset output", nb_rd_data, '0);
        check(!fifo_wr_push, "R7 master reset push", 36'(fifo_wr_push), '0);
    endtask

    task automatic do_prst();
        part_rst = 1'b1; nb_rd_en = 1'b0; nb_wr_en = 1'b0;
        @(posedge clk); @(negedge clk);
        part_rst = 1'b0;
        clear_model();
        check(nb_rd_data == '0, "R7 partial reset output", nb_rd_data, '0);
        check(!fifo_wr_push, "R7 partial reset push", 36'(fifo_wr_push), '0);
    endtask

    task automatic traffic(int n);
        for (int i = 0; i < n; i++) begin
            if (rq.size() < 3 && ($urandom % 2) == 0) rq.push_back(36'({$urandom, $urandom}));
            step(($urandom % 4) != 0, ($urandom % 3) != 0, 36'({$urandom, $urandom}));
        end
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        @(negedge clk);

        // directed: byte mode, big endian, known word (R3, R4)
        do_mrst(1'b1, 1'b1, 1'b1);
        tag = "R3/R4/R6";
        rq.push_back(36'h1_2345_6789);
        for (int k = 0; k < 4; k++) step(1'b1, 1'b1, 36'hF_FFFF_FE00 | 36'(k + 1));
        // directed: byte little endian (R3, R5)
        do_mrst(1'b1, 1'b1, 1'b0);
        tag = "R3/R5";
        rq.push_back(36'hA_BCDE_F012);
        step(1'b1, 1'b0, '0);
        step(1'b0, 1'b0, '0);       // idle mid-word
        rq.delete(); step(1'b1, 1'b0, '0); // empty FIFO with request
        rq.push_back(36'hA_BCDE_F012);
        for (int k = 0; k < 3; k++) step(1'b1, 1'b1, 36'(k + 5));
        step(1'b0, 1'b1, 36'h3);

        // random traffic in each configuration
        do_mrst(1'b0, 1'b0, 1'b1); tag = "R1/R6";    traffic(300);
        do_mrst(1'b1, 1'b0, 1'b1); tag = "R2/R4/R6"; traffic(300);
        do_mrst(1'b1, 1'b0, 1'b0); tag = "R2/R5/R6"; traffic(300);
        do_mrst(1'b1, 1'b1, 1'b1); tag = "R3/R4/R6"; traffic(300);
        do_mrst(1'b1, 1'b1, 1'b0); tag = "R3/R5/R6"; traffic(300);

        // partial reset mid-word: byte big endian kept (R10, R6)
        do_mrst(1'b1, 1'b1, 1'b1);
        rq.delete();
        rq.push_back(36'h0_1357_9BDF);
        tag = "R10";
        step(1'b1, 1'b1, 36'h0AA);
        step(1'b1, 1'b1, 36'h0BB);
        do_prst();
        tag = "R10/R6";
        for (int k = 0; k < 4; k++) step(1'b1, 1'b1, 36'(9'h101 + k));
        traffic(100);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule